// File: doc/BRIEF.md
# Burst Column Address Generator

This block produces the column address of every beat of one memory burst, starting from a 10-bit column given with a start pulse. A two-bit length select picks a burst of 2, 4 or 8 beats, or a full-page burst that runs over the whole 1024-column row. A mode input picks sequential or interleaved ordering for the fixed-length bursts. A terminate pulse ends any burst early. A new start pulse always takes over, even in the middle of a burst.

The core is a three-state machine. `ST_IDLE` emits nothing. `ST_FIXED` steps through a 2-, 4- or 8-beat burst. `ST_PAGE` steps through a full-page burst until it is terminated. The transitions are as follows. *launch-fixed*: any state goes to `ST_FIXED` on a start with a fixed length. *launch-page*: any state goes to `ST_PAGE` on a start with the page length. *finish*: `ST_FIXED` goes to `ST_IDLE` after its final beat. *abort*: `ST_FIXED` or `ST_PAGE` goes to `ST_IDLE` on a terminate. *hold*: every other case stays in the current state.

The start column, length and ordering are captured in registers when the start pulse is taken. The address is then formed from those registers and a beat counter. The datapath is kept separate from the state machine.

Top module: `burst_colgen`

## Requirements
- R1: In the cycle after a start pulse is sampled, `col_valid` is 1 and `col_addr` equals the start column (beat 0).
- R2: `len_sel` encodes the burst length: 0 = 2 beats, 1 = 4 beats, 2 = 8 beats, 3 = full page.
- R3: With `interleave` = 0 and a fixed length L, beat n's low log2(L) address bits are (start low bits + n) mod L, and the upper bits stay equal to the start column's.
- R4: With `interleave` = 1 and a fixed length L, beat n's low log2(L) bits are the start low bits XOR n, and the upper bits are unchanged.
- R5: A full-page burst increments the address by one per beat modulo 1024, wraps from 1023 to 0, and ignores `interleave`.
- R6: `col_last` is 1 only on the final beat of a fixed-length burst and is never 1 during a full-page burst.
- R7: On the clock after the final beat of a fixed-length burst, `col_valid` returns to 0 unless a new start is sampled on that edge.
- R8: A terminate pulse sampled during a burst, without a start, makes `col_valid` 0 from the next cycle on; the beat shown while it was high is still delivered.
- R9: A start pulse sampled during an active burst restarts the sequence from the new start column with the newly selected length and ordering. Start takes priority over terminate on the same edge.
- R10: While reset is asserted and after it is released, `col_valid` and `col_last` are 0 until a start is sampled.
- R11: Length and ordering are captured at the start; changing `len_sel` or `interleave` during a burst has no effect on the addresses or the burst length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to begin a burst |
| start_col | input | 10 | First column of the burst |
| len_sel | input | 2 | Burst length code (see R2) |
| interleave | input | 1 | 1 = interleaved order, 0 = sequential order |
| term | input | 1 | One-cycle request to stop the current burst |
| col_addr | output | 10 | Column address of the current beat |
| col_valid | output | 1 | `col_addr` holds a beat of a burst |
| col_last | output | 1 | Current beat is the final one of a fixed burst |

## Verification
The hardest case to reach is the full-page wrap from column 1023 back to 0, combined with the fact that a page burst never ends by itself. The stimulus starts a page burst a few columns below the top of the row with `interleave` set, lets it run more than 1024 beats, and only then terminates it. Every beat is compared against the scoreboard, so both the wrap and the absence of `col_last` are checked. Restarts are placed at chosen beats by counting edges from the start. This shows that a second start replaces the outstanding beats of the first burst, including when a terminate is sampled on the same edge.

// File: rtl/colgen_pkg.sv
package colgen_pkg;
    localparam int COL_W = 10;

    typedef enum logic [1:0] {
        LEN_2    = 2'd0,
        LEN_4    = 2'd1,
        LEN_8    = 2'd2,
        LEN_PAGE = 2'd3
    } len_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FIXED = 2'd1,
        ST_PAGE  = 2'd2
    } gen_state_e;

    // Mask covering the bits that move inside one burst
    function automatic logic [COL_W-1:0] wrap_mask(input len_e len);
        logic [COL_W-1:0] m;
        unique case (len)
            LEN_2:    m = COL_W'(1);
            LEN_4:    m = COL_W'(3);
            LEN_8:    m = COL_W'(7);
            default:  m = '1;
        endcase
        return m;
    endfunction
endpackage

// File: rtl/colgen_datapath.sv
module colgen_datapath
    import colgen_pkg::*;
#(
    parameter int AW = COL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          advance,
    input  logic [AW-1:0] start_col,
    input  len_e          len_in,
    input  logic          il_in,
    output logic [AW-1:0] addr,
    output logic          page_mode,
    output logic          beat_final
);
    localparam int FIX_BITS = 3;

    logic [AW-1:0] base_q;
    logic [AW-1:0] beat_q;
    len_e          len_q;
    logic          il_q;
    logic [AW-1:0] mask;
    logic [AW-1:0] seq_low;
    logic [AW-1:0] xor_low;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            beat_q <= '0;
            len_q  <= LEN_2;
            il_q   <= 1'b0;
        end else if (load) begin
            base_q <= start_col;
            beat_q <= '0;
            len_q  <= len_in;
            il_q   <= il_in;
        end else if (advance) begin
            beat_q <= beat_q + AW'(1);
        end
    end

    always_comb begin
        mask       = AW'(wrap_mask(len_q));
        page_mode  = (len_q == LEN_PAGE);
        seq_low    = (base_q + beat_q) & mask;
        xor_low    = (base_q ^ beat_q) & mask;
        beat_final = !page_mode && (beat_q == mask);
        if (page_mode)
            addr = base_q + beat_q;
        else if (il_q)
            addr = (base_q & ~mask) | xor_low;
        else
            addr = (base_q & ~mask) | seq_low;
    end

    AST_FIXED_UPPER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !load && !page_mode) |=> (addr[AW-1:FIX_BITS] == $past(addr[AW-1:FIX_BITS]))); // R3
    AST_PAGE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !load && page_mode) |=> (addr == $past(addr) + AW'(1))); // R5
endmodule

// File: rtl/colgen_fsm.sv
module colgen_fsm
    import colgen_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic term,
    input  logic want_page,
    input  logic beat_final,
    output logic load,
    output logic advance,
    output logic valid,
    output logic last
);
    gen_state_e state_q;
    gen_state_e state_d;

    always_comb begin
        state_d = state_q;
        if (start) begin
            state_d = want_page ? ST_PAGE : ST_FIXED;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_IDLE;
                ST_FIXED: if (term || beat_final) state_d = ST_IDLE;
                ST_PAGE:  if (term) state_d = ST_IDLE;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        load    = start;
        advance = 1'b0;
        valid   = 1'b0;
        last    = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_FIXED: begin
                advance = 1'b1;
                valid   = 1'b1;
                last    = beat_final;
            end
            ST_PAGE: begin
                advance = 1'b1;
                valid   = 1'b1;
            end
            default: ;
        endcase
    end

    AST_END_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (last && !start) |=> !valid); // R7
    AST_TERM_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (term && !start) |=> !valid); // R8
    AST_LAST_NOT_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PAGE) |-> !last); // R6
endmodule

// File: rtl/burst_colgen.sv
module burst_colgen
    import colgen_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [COL_W-1:0] start_col,
    input  logic [1:0]       len_sel,
    input  logic             interleave,
    input  logic             term,
    output logic [COL_W-1:0] col_addr,
    output logic             col_valid,
    output logic             col_last
);
    len_e len_in;
    logic load;
    logic advance;
    logic page_mode;
    logic beat_final;

    assign len_in = len_e'(len_sel);

    colgen_datapath #(.AW(COL_W)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .advance   (advance),
        .start_col (start_col),
        .len_in    (len_in),
        .il_in     (interleave),
        .addr      (col_addr),
        .page_mode (page_mode),
        .beat_final(beat_final)
    );

    colgen_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .term      (term),
        .want_page (len_in == LEN_PAGE),
        .beat_final(beat_final),
        .load      (load),
        .advance   (advance),
        .valid     (col_valid),
        .last      (col_last)
    );

    AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (col_valid && col_addr == $past(start_col))); // R1
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !col_valid |-> !col_last); // R10
    AST_PAGE_NO_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid && page_mode) |-> !col_last); // R6
endmodule

// File: tb/burst_colgen_tb.sv
module burst_colgen_tb;
    typedef struct {
        logic [9:0] addr;
        logic       last;
        string      req;
    } beat_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [9:0] start_col = '0;
    logic [1:0] len_sel = '0;
    logic       interleave = 1'b0;
    logic       term = 1'b0;
    logic [9:0] col_addr;
    logic       col_valid;
    logic       col_last;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    beat_t sb[$];

    always #2.5 clk = ~clk;

    burst_colgen u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
        .len_sel(len_sel), .interleave(interleave), .term(term),
        .col_addr(col_addr), .col_valid(col_valid), .col_last(col_last)
    );

    function automatic int len_of(input logic [1:0] code);
        return (code == 2'd3) ? 1024 : (2 << code);
    endfunction

    function automatic logic [9:0] model_addr(input int col, input logic [1:0] code,
                                              input logic il, input int n);
        int l, low, blk;
        l = len_of(code);
        if (l == 1024) return 10'((col + n) % 1024);
        low = col % l;
        blk = col - low;
        if (il) return 10'(blk + (low ^ n));
        return 10'(blk + (low + n) % l);
    endfunction

    task automatic check(input string req, input logic ok, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Pushes the expected beats then pulses start; returns with beat 0 on the outputs.
    task automatic launch(input int col, input logic [1:0] code, input logic il,
                          input int nbeats, input string req);
        int l;
        l = len_of(code);
        for (int i = 0; i < nbeats; i++) begin
            beat_t b;
            b.addr = model_addr(col, code, il, i);
            b.last = (l != 1024) && (i == l - 1);
            b.req  = req;
            sb.push_back(b);
        end
        start_col = 10'(col); len_sel = code; interleave = il; start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
    endtask

    task automatic step(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic expect_idle(input string req);
        @(negedge clk);
        check(req, !col_valid && !col_last, int'(col_valid), 0);
        check(req, sb.size() == 0, sb.size(), 0);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Monitor: pops the scoreboard on every valid beat
    always @(negedge clk) begin
        if (rst_n && col_valid) begin
            if (sb.size() == 0) begin
                check("R7/R8 extra beat", 1'b0, int'(col_addr), -1);
            end else begin
                beat_t e;
                e = sb.pop_front();
                check(e.req, col_addr == e.addr, int'(col_addr), int'(e.addr));
                check({e.req, " R6 last"}, col_last == e.last, int'(col_last), int'(e.last));
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++; checks++;
            $display("FAIL watchdog actual=%0d expected<150000", cycles);
            finish_run();
        end
    end

    initial begin
        // R10: reset state
        step(3);
        @(negedge clk);
        check("R10 in reset", !col_valid && !col_last, int'(col_valid), 0);
        rst_n = 1'b1;
        step(2);
        expect_idle("R10 after reset");

        // R1 R2 R3 R7: sequential fixed bursts, natural end
        launch(13, 2'd0, 1'b0, 2, "R3 seq len2");  step(1); step(1); expect_idle("R7 len2");
        launch(13, 2'd1, 1'b0, 4, "R3 seq len4");  step(3); step(1); expect_idle("R7 len4");
        launch(13, 2'd2, 1'b0, 8, "R2 seq len8");  step(7); step(1); expect_idle("R7 len8");
        launch(1023, 2'd2, 1'b0, 8, "R3 seq top"); step(8); expect_idle("R7 top");

        // R4: interleaved
        launch(13, 2'd1, 1'b1, 4, "R4 il len4");   step(4); expect_idle("R7 il4");
        launch(646, 2'd2, 1'b1, 8, "R4 il len8");  step(8); expect_idle("R7 il8");
        launch(1, 2'd0, 1'b1, 2, "R4 il len2");    step(2); expect_idle("R7 il2");

        // R11: config changes mid-burst have no effect
        launch(300, 2'd2, 1'b1, 8, "R11 held cfg");
        len_sel = 2'd0; interleave = 1'b0;
        step(8); expect_idle("R11 length held");

        // R8: termination of fixed burst after beat 2
        launch(40, 2'd2, 1'b0, 3, "R8 fixed term");
        step(2); term = 1'b1; step(1); term = 1'b0;
        expect_idle("R8 fixed");

        // R5 R6: full page with wrap, interleave ignored
        launch(1020, 2'd3, 1'b1, 1030, "R5 page wrap");
        step(1029); term = 1'b1; step(1); term = 1'b0;
        expect_idle("R8 page");

        // R9: restart mid-burst, then start and term together
        launch(100, 2'd2, 1'b0, 4, "R9 first");
        step(3);
        launch(517, 2'd1, 1'b1, 4, "R9 second");
        step(4); expect_idle("R9 second end");
        launch(200, 2'd3, 1'b0, 5, "R9 page first");
        step(4);
        term = 1'b1;
        launch(60, 2'd0, 1'b0, 2, "R9 start beats term");
        term = 1'b0;
        step(2); expect_idle("R9 restart end");

        finish_run();
    end
endmodule